// File: doc/BRIEF.md
# Two-Stage Fetch-Execute Instruction Core

This block is a small instruction sequencer for an 8-bit controller with separate program and data spaces. Program memory is read one 16-bit word at a time through a port addressed by a word-granular program counter. The read is combinational: the word for `pm_addr` is expected on `pm_data` in the same cycle. The core knows five operations: load-immediate, register add, store-direct, jump and no-operation. It keeps 32 eight-bit registers internally. A store-direct sends a byte out on a simple data-space write bus.

The core has two overlapped stages. The fetch stage latches the word at the program counter into an instruction register. The execute stage decodes the instruction register in the same cycle that fetch reads the following word, so single-word instructions retire at one per clock.

Store-direct and jump are two words long. For these, the word on `pm_data` during execute is taken as the operand. That operand word is then dropped rather than latched for decoding, which costs one bubble cycle. A jump reloads the program counter with its target, and the first word fetched from there executes two cycles after the jump.

Top module: `fx_core`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `pm_addr` is 0 and `d_we` is 0. All 32 registers are cleared to 0 by reset.
- R2: A word with bits 15:12 = 4'hE is load-immediate. It writes the byte {w[11:8], w[3:0]} into register 16 + w[7:4] (for example 16'hE205 loads 8'h25 into register 16).
- R3: A word with bits 15:10 = 6'b000011 is add. It writes (Rd + Rr) mod 256 into Rd, where d = {w[8], w[7:4]} and r = {w[9], w[3:0]} (for example 16'h0F01 adds register 17 into register 16).
- R4: A word with bits 15:9 = 7'b1001001 and bits 3:0 = 0 is store-direct from register {w[8], w[7:4]}. In its execute cycle, `d_we` is 1 for exactly one cycle, `d_addr` holds the following program word and `d_wdata` holds the register value.
- R5: The word 16'h940C is jump. The following program word is the target. The next `pm_addr` is the target, no word between the jump and the target executes, and the word at the target executes two cycles after the jump.
- R6: Single-word instructions complete one per clock. `pm_addr` advances by one each cycle, and an instruction fetched from address n executes in the cycle when `pm_addr` is n + 1.
- R7: The second word of a store-direct or jump is used only as an operand and is never executed, even when its bit pattern encodes another instruction.
- R8: The word 16'h0000 and every word matching none of the encodings in R2 to R5 change no register and produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pm_addr | output | PC_W | Program memory word address |
| pm_data | input | 16 | Program memory word at `pm_addr`, same cycle |
| d_addr | output | 16 | Data-space write address |
| d_wdata | output | 8 | Data-space write byte |
| d_we | output | 1 | Data-space write enable |

## Verification
In one test the operand word of a store is itself a valid load-immediate encoding. A core that decoded operand words would overwrite the register with that operand's immediate, and the next store would show the wrong byte. Another test places a load and a store between a jump and its target. If the flush were missing, a write to the skipped address would appear, and a late target load would show up as a wrong `pm_addr` two cycles in. Further tests cover the following:
- add wrap-around past 8'hFF, and the high-register encodings (register 31);
- unrecognised words such as 16'hFFFF and 16'h1234;
- the exact cycle of each write, which exposes any stall added to single-word execution;
- a program that reads a register written before a reset, which exposes a register file that reset leaves uncleared.

// File: rtl/fx_core.sv
module fx_core #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] pm_addr,
  input  logic [15:0]     pm_data,
  output logic [15:0]     d_addr,
  output logic [7:0]      d_wdata,
  output logic            d_we
);
  localparam int NREG = 32;

  logic [PC_W-1:0] pc;
  logic [15:0]     ir;
  logic            valid;
  logic [7:0]      rf [NREG];

  logic       is_ldi, is_add, is_sts, is_jmp;
  logic [4:0] rd, rr, ldi_rd;
  logic [7:0] ldi_k, sum;

  assign is_ldi = valid && ir[15:12] == 4'hE;
  assign is_add = valid && ir[15:10] == 6'b000011;
  assign is_sts = valid && ir[15:9] == 7'b1001001 && ir[3:0] == 4'h0;
  assign is_jmp = valid && ir == 16'h940C;

  assign rd     = {ir[8], ir[7:4]};
  assign rr     = {ir[9], ir[3:0]};
  assign ldi_rd = {1'b1, ir[7:4]};
  assign ldi_k  = {ir[11:8], ir[3:0]};
  assign sum    = rf[rd] + rf[rr];

  assign pm_addr = pc;
  assign d_we    = is_sts;
  assign d_addr  = pm_data;
  assign d_wdata = rf[rd];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      ir    <= '0;
      valid <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (is_jmp) begin
        pc    <= pm_data[PC_W-1:0];
        valid <= 1'b0;
      end else if (is_sts) begin
        pc    <= pc + 1'b1;
        valid <= 1'b0;
      end else begin
        pc    <= pc + 1'b1;
        ir    <= pm_data;
        valid <= 1'b1;
      end
      if (is_ldi) rf[ldi_rd] <= ldi_k;
      if (is_add) rf[rd] <= sum;
    end
  end

  AST_RESET_PC: assert property (@(posedge clk) rst |=> (pm_addr == '0 && !d_we)); // R1
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (valid && !is_jmp) |=> (pm_addr == $past(pm_addr) + 1'b1)); // R6
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    is_jmp |=> (pm_addr == $past(pm_data[PC_W-1:0]) && !valid)); // R5
  AST_OPERAND_SKIP: assert property (@(posedge clk) disable iff (rst)
    is_sts |=> !valid); // R7
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    d_we |=> !d_we); // R4
endmodule

// File: tb/sim_fx_core.sv
module sim_fx_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pm_addr;
  logic [15:0] pm_data;
  logic [15:0] d_addr;
  logic [7:0]  d_wdata;
  logic        d_we;

  logic [15:0] pmem [256];
  logic [15:0] log_addr [16];
  logic [7:0]  log_data [16];
  int          log_cyc [16];
  int          nlog, cyc;
  int          n_chk = 0, n_bad = 0;
  int          wd = 0;

  always #2.5 clk = ~clk;

  fx_core #(.PC_W(16)) u0 (
    .clk(clk), .rst(rst), .pm_addr(pm_addr), .pm_data(pm_data),
    .d_addr(d_addr), .d_wdata(d_wdata), .d_we(d_we)
  );

  assign pm_data = pmem[pm_addr[7:0]];

  always @(posedge clk) begin
    if (rst) begin
      nlog <= 0;
      cyc  <= 0;
    end else begin
      cyc <= cyc + 1;
      if (d_we && nlog < 16) begin
        log_addr[nlog] <= d_addr;
        log_data[nlog] <= d_wdata;
        log_cyc[nlog]  <= cyc;
        nlog <= nlog + 1;
      end
    end
  end

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 20000) begin
      n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=20000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic clear_mem;
    for (int i = 0; i < 256; i++) pmem[i] = 16'h0000;
  endtask

  task automatic start;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    clear_mem();
    pmem[0] = 16'hE707; pmem[1] = 16'h0E50; pmem[2] = 16'h940C; pmem[3] = 16'h0002;
    start();
    run(10);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    eq("R1 pm_addr in reset", pm_addr, 0);
    eq("R1 d_we in reset", d_we, 0);
    clear_mem();
    pmem[0] = 16'h9250; pmem[1] = 16'h0060; pmem[2] = 16'h940C; pmem[3] = 16'h0002;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    eq("R1 pm_addr after reset", pm_addr, 0);
    run(12);
    eq("R1 write count", nlog, 1);
    eq("R1 register 5 cleared", log_data[0], 8'h00);
    eq("R1 address", log_addr[0], 16'h0060);
  endtask

  task automatic t_sample_program;
    clear_mem();
    pmem[0] = 16'hE205; pmem[1] = 16'hE314; pmem[2] = 16'hE321; pmem[3] = 16'h0F01;
    pmem[4] = 16'h0F02; pmem[5] = 16'hE01B; pmem[6] = 16'h0F01; pmem[7] = 16'h9300;
    pmem[8] = 16'h0300; pmem[9] = 16'h940C; pmem[10] = 16'h0009;
    start();
    run(3);
    eq("R6 pm_addr after 3 clocks", pm_addr, 3);
    run(40);
    eq("R4 write count", nlog, 1);
    eq("R4 store address", log_addr[0], 16'h0300);
    eq("R2/R3 sum 0x25+0x34+0x31+0x0B", log_data[0], 8'h95);
    eq("R6 store cycle", log_cyc[0], 8);
    chk(pm_addr == 9 || pm_addr == 10, "R5 halt loop pm_addr", pm_addr, 9);
  endtask

  task automatic t_add_wrap;
    clear_mem();
    pmem[0] = 16'hE90C; pmem[1] = 16'hE614; pmem[2] = 16'h0F01; pmem[3] = 16'h9300;
    pmem[4] = 16'h0070; pmem[5] = 16'hEFF0; pmem[6] = 16'h0FF1; pmem[7] = 16'h93F0;
    pmem[8] = 16'h0071; pmem[9] = 16'h940C; pmem[10] = 16'h0009;
    start();
    run(30);
    eq("R3 write count", nlog, 2);
    eq("R3 wrap 0x9C+0x64", log_data[0], 8'h00);
    eq("R4 first address", log_addr[0], 16'h0070);
    eq("R3 register 31 0xF0+0x64", log_data[1], 8'h54);
    eq("R4 second address", log_addr[1], 16'h0071);
  endtask

  task automatic t_operand;
    clear_mem();
    pmem[0] = 16'hE0F7; pmem[1] = 16'h93F0; pmem[2] = 16'hE2FF; pmem[3] = 16'h93F0;
    pmem[4] = 16'h0040; pmem[5] = 16'h940C; pmem[6] = 16'h0005;
    start();
    run(20);
    eq("R7 write count", nlog, 2);
    eq("R7 operand as address", log_addr[0], 16'hE2FF);
    eq("R7 register 31 untouched by operand", log_data[1], 8'h07);
    eq("R7 first store cycle", log_cyc[0], 2);
    eq("R7 second store cycle after bubble", log_cyc[1], 4);
  endtask

  task automatic t_jump;
    clear_mem();
    pmem[0] = 16'h940C; pmem[1] = 16'h0005; pmem[2] = 16'hEA0A; pmem[3] = 16'h9300;
    pmem[4] = 16'h0010; pmem[5] = 16'hE101; pmem[6] = 16'h9300; pmem[7] = 16'h0020;
    pmem[8] = 16'h940C; pmem[9] = 16'h0008;
    start();
    run(2);
    eq("R5 pm_addr is target", pm_addr, 5);
    run(20);
    eq("R5 write count (skipped store absent)", nlog, 1);
    eq("R5 target store address", log_addr[0], 16'h0020);
    eq("R5 skipped load absent", log_data[0], 8'h11);
    eq("R5 target store cycle", log_cyc[0], 4);
  endtask

  task automatic t_nop;
    clear_mem();
    pmem[0] = 16'hE50A; pmem[1] = 16'hFFFF; pmem[2] = 16'h0000; pmem[3] = 16'h1234;
    pmem[4] = 16'h9300; pmem[5] = 16'h0050; pmem[6] = 16'h940C; pmem[7] = 16'h0006;
    start();
    run(3);
    eq("R8 no write during unknown words", nlog, 0);
    run(20);
    eq("R8 write count", nlog, 1);
    eq("R8 register 16 kept", log_data[0], 8'h5A);
    eq("R8 address", log_addr[0], 16'h0050);
    eq("R6 store cycle after no-ops", log_cyc[0], 5);
  endtask

  initial begin
    t_reset();
    t_sample_program();
    t_add_wrap();
    t_operand();
    t_jump();
    t_nop();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule